// File: doc/BRIEF.md
# Time-Base Bit-Select Interval Timer

A periodic event source driven from a free-running 64-bit time base. Software does not load a count. It picks which time-base bit's 0-to-1 transition raises the event, so the interval for selected bit n is 2^(n+1) time-base ticks. Each event sets a sticky status flag. A level interrupt is requested while that flag and its enable are both set.

The selected bit is decoded in one of two ways, fixed at build time. In table mode, a 2-bit period field indexes a four-entry table of bit positions. In extended mode, the period field and a 4-bit extension field are joined into a 6-bit value v = period | (ext << 2), and the selected bit is 63 - v. The block has a control-register write port and a write-1-to-clear status port.

Top module: `fit_interval_timer`

## Requirements
- R1: The time base `tb_o` resets to 0. It increments by exactly one on each clock edge where `tick_i` is 1, holds otherwise, and wraps modulo 2^64.
- R2: In table mode, `sel_idx_o` equals the table entry indexed by control bits 25:24. The default table is 0→2, 1→4, 2→6, 3→0.
- R3: In extended mode, `sel_idx_o` equals 63 - (ctrl[25:24] | ctrl[16:13] << 2). Bit 0 is the least significant time-base bit.
- R4: An event fires exactly when the selected time-base bit goes from 0 to 1. `fire_o` is high for the one cycle in which `tb_o` first shows that bit set. Over any 2^(n+1) consecutive ticks, exactly one event occurs.
- R5: The status flag `stat_o` becomes 1 in the same cycle as `fire_o`. It stays 1 until it is cleared.
- R6: A status write with write-data bit 26 at 1 clears the flag. With bit 26 at 0, the write leaves the flag unchanged. All other write-data bits are ignored.
- R7: An event in the same cycle as a clearing status write leaves the flag set.
- R8: `irq_o` is 1 while the flag and the enable at control bit 23 are both 1. Setting the enable while the flag is already set raises `irq_o` in the next cycle.
- R9: Writing a new period or extension field never creates an event by itself. The next event comes at the next 0-to-1 transition of the newly selected bit.
- R10: After reset, the flag, `irq_o`, `fire_o` and all control fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base advance enable |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 32 | Control write data: period 25:24, enable 23, extension 16:13 |
| stat_we_i | input | 1 | Status write strobe (write-1-to-clear) |
| stat_wdata_i | input | 32 | Status write data: bit 26 clears the flag |
| tb_o | output | 64 | Current time base |
| sel_idx_o | output | 6 | Currently selected time-base bit |
| fire_o | output | 1 | One-cycle event pulse |
| stat_o | output | 1 | Sticky interval status flag |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench retargets the selector while the newly chosen bit is already 1. A design that compared a stored previous bit value would fire a spurious event there, and one that reset the phase would fire late. It lines a clearing status write up with the exact tick that fires, which catches a design that lets the clear win and loses the event. It also checks a clear with bit 26 at 0 and an enable raised after the flag is already set; wrong handling shows as a dropped flag or a missing interrupt. Event counts over whole intervals, under gapped tick patterns, expose an off-by-one bit select or a mirrored index decoded the wrong way round.

// File: rtl/fit_pkg.sv
`timescale 1ns/1ps
package fit_pkg;
  typedef struct packed {
    logic [3:0] ext;
    logic [1:0] per;
    logic       ie;
  } fit_ctrl_t;
endpackage

// File: rtl/fit_time_base.sv
`timescale 1ns/1ps
module fit_time_base #(
  parameter int unsigned TB_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  output logic [TB_W-1:0] tb_o,
  output logic [TB_W-1:0] rise_o
);
  logic [TB_W-1:0] tb_q;
  logic [TB_W-1:0] tb_inc;

  assign tb_inc = tb_q + TB_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tb_q <= '0;
    else if (tick_i) tb_q <= tb_inc;
  end

  // bits that go 0->1 on the next increment
  assign rise_o = ~tb_q & tb_inc;
  assign tb_o   = tb_q;

  assert_tb_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> tb_q == $past(tb_q) + TB_W'(1));
  assert_tb_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(tb_q));
endmodule

// File: rtl/fit_bit_select.sv
`timescale 1ns/1ps
module fit_bit_select #(
  parameter int unsigned TB_W      = 64,
  parameter int unsigned IDX_W     = 6,
  parameter bit          EXT_MODE  = 1'b0,
  parameter logic [4*IDX_W-1:0] BIT_TABLE = '0
) (
  input  logic [1:0]       per_i,
  input  logic [3:0]       ext_i,
  output logic [IDX_W-1:0] sel_o
);
  generate
    if (EXT_MODE) begin : g_ext
      logic [5:0] mix;
      assign mix   = {ext_i, per_i};
      // mirrored index: 0 selects the top bit
      assign sel_o = IDX_W'(TB_W - 1) - IDX_W'(mix);
    end else begin : g_tbl
      logic [3:0] unused_ext;
      assign unused_ext = ext_i;
      assign sel_o = BIT_TABLE[per_i*IDX_W +: IDX_W];
    end
  endgenerate
endmodule

// File: rtl/fit_status.sv
`timescale 1ns/1ps
module fit_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic st_o,
  output logic irq_o
);
  logic st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= 1'b0;
    else if (set_i)  st_q <= 1'b1;   // event beats clear
    else if (clr_i)  st_q <= 1'b0;
  end

  assign st_o  = st_q;
  assign irq_o = st_q & ie_i;

  assert_set_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> st_q);
  assert_set_over_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i) |=> st_q);
  assert_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !st_q);
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(st_q));
endmodule

// File: rtl/fit_interval_timer.sv
`timescale 1ns/1ps
module fit_interval_timer #(
  parameter int unsigned TB_W     = 64,
  parameter int unsigned REG_W    = 32,
  parameter int unsigned PER_LSB  = 24,
  parameter int unsigned EXT_LSB  = 13,
  parameter int unsigned IE_POS   = 23,
  parameter int unsigned ST_POS   = 26,
  parameter bit          EXT_MODE = 1'b0,
  parameter logic [4*$clog2(TB_W)-1:0] BIT_TABLE = {6'd0, 6'd6, 6'd4, 6'd2}
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic                     ctrl_we_i,
  input  logic [REG_W-1:0]         ctrl_wdata_i,
  input  logic                     stat_we_i,
  input  logic [REG_W-1:0]         stat_wdata_i,
  output logic [TB_W-1:0]          tb_o,
  output logic [$clog2(TB_W)-1:0]  sel_idx_o,
  output logic                     fire_o,
  output logic                     stat_o,
  output logic                     irq_o
);
  import fit_pkg::*;

  localparam int unsigned IDX_W = $clog2(TB_W);

  fit_ctrl_t       ctrl_q;
  logic [TB_W-1:0] tb;
  logic [TB_W-1:0] rise;
  logic [IDX_W-1:0] sel;
  logic            fire;
  logic            fire_q;
  logic            clr;
  logic [IDX_W-1:0] sel_d;
  logic            unused_wdata;

  assign unused_wdata = ^{ctrl_wdata_i, stat_wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_we_i) begin
      ctrl_q.ext <= ctrl_wdata_i[EXT_LSB +: 4];
      ctrl_q.per <= ctrl_wdata_i[PER_LSB +: 2];
      ctrl_q.ie  <= ctrl_wdata_i[IE_POS];
    end
  end

  fit_time_base #(.TB_W(TB_W)) i_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .tb_o   (tb),
    .rise_o (rise)
  );

  fit_bit_select #(
    .TB_W      (TB_W),
    .IDX_W     (IDX_W),
    .EXT_MODE  (EXT_MODE),
    .BIT_TABLE (BIT_TABLE)
  ) i_sel (
    .per_i (ctrl_q.per),
    .ext_i (ctrl_q.ext),
    .sel_o (sel)
  );

  // edge taken from the carry into the selected bit: selector changes cannot fire
  assign fire = tick_i & rise[sel];
  assign clr  = stat_we_i & stat_wdata_i[ST_POS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fire_q <= 1'b0;
      sel_d  <= '0;
    end else begin
      fire_q <= fire;
      sel_d  <= sel;
    end
  end

  fit_status i_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (fire),
    .clr_i  (clr),
    .ie_i   (ctrl_q.ie),
    .st_o   (stat_o),
    .irq_o  (irq_o)
  );

  assign tb_o      = tb;
  assign sel_idx_o = sel;
  assign fire_o    = fire_q;

  assert_fire_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |-> (tb[sel_d] && ((tb & ((TB_W'(1) << sel_d) - TB_W'(1))) == '0)));
  assert_no_fire_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !fire_q);
  assert_fire_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |-> stat_o);
endmodule

// File: tb/test_fit_interval_timer.sv
`timescale 1ns/1ps
module test_fit_interval_timer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        ctrl_we_i = 1'b0;
  logic [31:0] ctrl_wdata_i = '0;
  logic        stat_we_i = 1'b0;
  logic [31:0] stat_wdata_i = '0;

  logic [63:0] tb_n, tb_x;
  logic [5:0]  sel_n, sel_x;
  logic        fire_n, fire_x, stat_n, stat_x, irq_n, irq_x;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  longint unsigned mtb = 0;
  int  msel [2];
  bit  mstat [2];
  bit  mfire [2];
  bit  mie = 1'b0;

  always #2.5 clk = ~clk;

  fit_interval_timer #(.EXT_MODE(1'b0)) i_fit_interval_timer (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i),
    .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
    .stat_we_i(stat_we_i), .stat_wdata_i(stat_wdata_i),
    .tb_o(tb_n), .sel_idx_o(sel_n), .fire_o(fire_n), .stat_o(stat_n), .irq_o(irq_n));

  fit_interval_timer #(.EXT_MODE(1'b1)) i_fit_interval_timer_ext (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i),
    .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
    .stat_we_i(stat_we_i), .stat_wdata_i(stat_wdata_i),
    .tb_o(tb_x), .sel_idx_o(sel_x), .fire_o(fire_x), .stat_o(stat_x), .irq_o(irq_x));

  function automatic int tbl(input int p);
    case (p)
      0: return 2;
      1: return 4;
      2: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] mk_ctrl(input int per, input int ext, input bit ie);
    return (32'(per) << 24) | (32'(ext) << 13) | (32'(ie) << 23);
  endfunction

  function automatic bit bit_rises(input longint unsigned t, input int n);
    longint unsigned nx;
    nx = t + 1;
    return nx[n] && !t[n];
  endfunction

  task automatic chk(input bit ok, input string what, input longint unsigned act,
                     input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic step(input bit tk, input bit cwe, input logic [31:0] cd,
                      input bit swe, input logic [31:0] sd, input string tag);
    @(negedge clk);
    tick_i = tk; ctrl_we_i = cwe; ctrl_wdata_i = cd;
    stat_we_i = swe; stat_wdata_i = sd;
    for (int k = 0; k < 2; k++) begin
      mfire[k] = tk && bit_rises(mtb, msel[k]);
      if (mfire[k])            mstat[k] = 1'b1;
      else if (swe && sd[26])  mstat[k] = 1'b0;
    end
    if (tk) mtb = mtb + 1;
    if (cwe) begin
      mie     = cd[23];
      msel[0] = tbl(int'(cd[25:24]));
      msel[1] = 63 - int'({cd[16:13], cd[25:24]});
    end
    @(posedge clk);
    #1;
    chk(tb_n == mtb, {"R1 tb table ", tag}, tb_n, mtb);
    chk(tb_x == mtb, {"R1 tb ext ", tag}, tb_x, mtb);
    chk(sel_n == 6'(msel[0]), {"R2 sel table ", tag}, sel_n, msel[0]);
    chk(sel_x == 6'(msel[1]), {"R3 sel ext ", tag}, sel_x, msel[1]);
    chk(fire_n == mfire[0], {"R4 fire table ", tag}, fire_n, mfire[0]);
    chk(fire_x == mfire[1], {"R4 fire ext ", tag}, fire_x, mfire[1]);
    chk(stat_n == mstat[0], {"R5 stat table ", tag}, stat_n, mstat[0]);
    chk(stat_x == mstat[1], {"R5 stat ext ", tag}, stat_x, mstat[1]);
    chk(irq_n == (mstat[0] & mie), {"R8 irq table ", tag}, irq_n, mstat[0] & mie);
    chk(irq_x == (mstat[1] & mie), {"R8 irq ext ", tag}, irq_x, mstat[1] & mie);
    tick_i = 1'b0; ctrl_we_i = 1'b0; stat_we_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    #1;
    chk(tb_n == 0 && tb_x == 0, "R10 tb reset", tb_n, 0);
    chk(!stat_n && !stat_x, "R10 stat reset", stat_n, 0);
    chk(!irq_n && !irq_x, "R10 irq reset", irq_n, 0);
    chk(!fire_n && !fire_x, "R10 fire reset", fire_n, 0);
    chk(sel_n == 6'd2, "R10 ctrl reset table sel", sel_n, 2);
    chk(sel_x == 6'd63, "R10 ctrl reset ext sel", sel_x, 63);
  endtask

  task automatic t_periods();
    for (int p = 0; p < 4; p++) begin
      int cn, cx;
      cn = 0; cx = 0;
      step(1'b0, 1'b1, mk_ctrl(p, 15, 1'b1), 1'b0, '0, "R2 setup");
      for (int i = 0; i < 128; i++) begin
        step(1'b1, 1'b0, '0, 1'b1, 32'h0400_0000, "R4 period");
        cn += int'(fire_n);
        cx += int'(fire_x);
      end
      chk(cn == (128 >> (tbl(p) + 1)), "R4 table event count", cn, 128 >> (tbl(p) + 1));
      chk(cx == (128 >> (4 - p)), "R3 ext event count", cx, 128 >> (4 - p));
    end
  endtask

  task automatic t_gapped();
    step(1'b0, 1'b1, mk_ctrl(0, 14, 1'b0), 1'b0, '0, "R3 setup");
    for (int i = 0; i < 300; i++)
      step((i % 3) != 0, 1'b0, '0, (i % 7) == 0, 32'h0400_0000, "R1 gapped");
  endtask

  task automatic t_irq();
    step(1'b0, 1'b1, mk_ctrl(3, 15, 1'b0), 1'b1, 32'hFFFF_FFFF, "R8 setup");
    step(1'b1, 1'b0, '0, 1'b0, '0, "R8 tick");
    step(1'b1, 1'b0, '0, 1'b0, '0, "R8 tick");
    chk(stat_n && !irq_n, "R8 flag set, irq masked", irq_n, 0);
    step(1'b0, 1'b1, mk_ctrl(3, 15, 1'b1), 1'b0, '0, "R8 enable late");
    chk(irq_n && irq_x, "R8 irq after late enable", irq_n, 1);
    step(1'b0, 1'b0, '0, 1'b1, 32'hFBFF_FFFF, "R6 clear bit zero");
    chk(stat_n && stat_x, "R6 write of 0 ignored", stat_n, 1);
    step(1'b0, 1'b0, '0, 1'b1, 32'h0400_0000, "R6 clear");
    chk(!stat_n && !irq_n, "R6 w1c clears flag and irq", stat_n, 0);
  endtask

  task automatic t_set_beats_clear();
    if (mtb[0]) step(1'b1, 1'b0, '0, 1'b1, 32'h0400_0000, "R7 align");
    step(1'b0, 1'b0, '0, 1'b1, 32'h0400_0000, "R7 pre-clear");
    step(1'b1, 1'b0, '0, 1'b1, 32'h0400_0000, "R7 collide");
    chk(stat_n && stat_x && fire_n, "R7 event wins over clear", stat_n, 1);
  endtask

  task automatic t_retarget();
    int waited, expw;
    longint unsigned ph;
    step(1'b0, 1'b1, mk_ctrl(3, 15, 1'b1), 1'b0, '0, "R9 bit0");
    while (!(mtb[6] && !mtb[0])) step(1'b1, 1'b0, '0, 1'b0, '0, "R9 walk");
    step(1'b0, 1'b0, '0, 1'b1, 32'h0400_0000, "R9 clear");
    // bit 6 is already 1 here: a stored-previous-bit design would fire now
    step(1'b0, 1'b1, mk_ctrl(2, 15, 1'b1), 1'b0, '0, "R9 retarget");
    step(1'b1, 1'b0, '0, 1'b0, '0, "R9 after");
    chk(!fire_n && !stat_n, "R9 no spurious event", stat_n, 0);
    ph = mtb % 128;
    expw = (ph < 64) ? int'(64 - ph) : int'(192 - ph);
    waited = 0;
    do begin
      step(1'b1, 1'b0, '0, 1'b0, '0, "R9 wait");
      waited++;
    end while (!fire_n && waited < 300);
    chk(waited == expw, "R9 first event on new bit edge", waited, expw);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp=%0d", checks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    msel[0] = 2; msel[1] = 63;
    mstat[0] = 1'b0; mstat[1] = 1'b0;
    repeat (3) @(posedge clk);
    t_reset();
    t_periods();
    t_gapped();
    t_irq();
    t_set_beats_clear();
    t_retarget();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule